// File: doc/BRIEF.md
# Burst-of-Four Late-Write SRAM Port

This block is the write side of a synchronous SRAM with separate input and output ports. A write command is an active-low strobe, sampled together with a word address on a rising edge of the main clock K. The data for that command arrives late. Four beats follow, starting on the next K rising edge and then on consecutive rising edges of K-bar, K and K-bar. Each beat carries per-byte write enables for 9-bit lanes. Every beat is committed to an internal memory array, and a lane whose enable is inactive keeps its old contents.

The block is synthesizable and runs on one clock at twice the K rate. The input `k_phase` is high on the fast-clock edges that stand for K rising and low on those that stand for K-bar rising. A command that arrives while a burst is still collecting waits in a single holding register, and its beats follow the current fourth beat without a gap. A simple registered read port exposes the array so that its contents can be observed.

Top module: `wb4_write_port`

## Requirements
- R1: A write command is taken only when `wr_n` is 0 on an edge with `k_phase`=1. `wr_n`=0 on an edge with `k_phase`=0 starts nothing.
- R2: Each command writes exactly four words: the captured address with its two low bits replaced by 0, 1, 2 and 3 in that order. The low two bits of `wr_addr` have no effect.
- R3: Beat 0 of an idle-start command is taken on the second edge after the command edge, which is the next K edge. Beats 1, 2 and 3 are taken on the three edges that follow.
- R4: Suppose a command is taken while a burst is collecting or is about to start. Its beat 0 is taken on the edge right after the previous burst's beat 3. Commands on every other K edge therefore give a gapless stream of beats.
- R5: The holding register has one entry. A command on a K edge where that entry is full and not being emptied is dropped, and the words it addresses stay unchanged.
- R6: `din` and `bw_n` are ignored on every edge that is not a beat of an accepted burst.
- R7: `din` has DW bits in 9-bit lanes. `bw_n[i]`=0 on a beat writes bits 9i to 9i+8 of that beat's word. `bw_n[i]`=1 leaves those bits unchanged.
- R8: Once a burst is accepted, all four of its beats are committed whatever `wr_n` does afterwards, including `wr_n` held at 1 (deselected).
- R9: `rd_data` shows the word at `rd_addr` one edge after it is sampled. It reads the old contents when the same word is written on that edge. It is 0 during reset.
- R10: Elaboration stops unless DW is 18 or 36 and AW is at least 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, two edges per K period |
| rst_n | input | 1 | Asynchronous active-low reset |
| k_phase | input | 1 | 1 = this edge is K rising, 0 = K-bar rising |
| wr_n | input | 1 | Active-low write strobe |
| wr_addr | input | AW | Write word address (low two bits unused) |
| din | input | DW | Late write data beat |
| bw_n | input | DW/9 | Active-low byte-lane enables, one per 9 bits |
| rd_addr | input | AW | Read word address |
| rd_data | output | DW | Registered read data |

## Verification
Every accepted command commits its words on the 2nd to 5th edges after the command edge, or on the edges right after an earlier burst's last beat when it was queued. The bench drives each scenario one fast-clock slot at a time, with the beat data placed in exactly those slots and junk data and enables in all other slots. It updates its reference array only for the beats the requirements accept. Read checks drive `rd_addr` in one slot and compare `rd_data` one edge later, away from the clock edge, and only after the last beat of every pending burst has been committed.

// File: rtl/wb4_pkg.sv
`timescale 1ns/1ps
package wb4_pkg;
   localparam int LANE_W     = 9;
   localparam int BEATS      = 4;
   localparam int BEAT_IDX_W = $clog2(BEATS);
endpackage

// File: rtl/wb4_sched.sv
`timescale 1ns/1ps
// Command capture, single-entry holding register and beat sequencing.
module wb4_sched import wb4_pkg::*; #(
   parameter  int AW = 6,
   localparam int UW = AW - BEAT_IDX_W
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          k_phase,
   input  logic          wr_n,
   input  logic [AW-1:0] cmd_addr,
   output logic          we,
   output logic [AW-1:0] waddr
);
   logic                  busy;
   logic [BEAT_IDX_W-1:0] cnt;
   logic [UW-1:0]         base;
   logic                  q_vld;
   logic [UW-1:0]         q_base;
   logic                  start;
   logic                  take;
   logic                  last;

   // A held command launches its beat 0 on a K edge when no burst runs.
   assign start = k_phase & q_vld & ~busy;
   // The holding slot accepts a command when empty or emptied this edge.
   assign take  = k_phase & ~wr_n & (~q_vld | start);
   assign last  = busy & (cnt == BEAT_IDX_W'(BEATS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         cnt    <= '0;
         base   <= '0;
         q_vld  <= 1'b0;
         q_base <= '0;
      end else begin
         if (take) begin
            q_vld  <= 1'b1;
            q_base <= cmd_addr[AW-1:BEAT_IDX_W];
         end else if (start) begin
            q_vld  <= 1'b0;
         end
         if (start) begin
            busy <= 1'b1;
            cnt  <= BEAT_IDX_W'(1);
            base <= q_base;
         end else if (busy) begin
            cnt <= cnt + BEAT_IDX_W'(1);
            if (last) busy <= 1'b0;
         end
      end
   end

   assign we    = busy | start;
   assign waddr = busy ? {base, cnt} : {q_base, {BEAT_IDX_W{1'b0}}};

   // R3: a burst's first word is written on a K edge
   p_beat0_on_k_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (we && waddr[BEAT_IDX_W-1:0] == '0) |-> k_phase);

   // R2: low address bits step by one on consecutive edges within a burst
   p_beat_seq_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (we && waddr[BEAT_IDX_W-1:0] != BEAT_IDX_W'(BEATS - 1)) |=>
      (we && waddr[BEAT_IDX_W-1:0] == $past(waddr[BEAT_IDX_W-1:0]) + BEAT_IDX_W'(1)));

   // R2: the upper address stays fixed during a burst
   p_base_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (we && waddr[BEAT_IDX_W-1:0] != BEAT_IDX_W'(BEATS - 1)) |=>
      (waddr[AW-1:BEAT_IDX_W] == $past(waddr[AW-1:BEAT_IDX_W])));

   // R5: a held command is never lost on a K-bar edge
   p_hold_kbar_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (q_vld && !k_phase) |=> q_vld);

   // R4: a held command follows the last beat without a gap
   p_gapless_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (last && q_vld) |=> (we && waddr[BEAT_IDX_W-1:0] == '0));
endmodule

// File: rtl/wb4_lane_mem.sv
`timescale 1ns/1ps
// One 9-bit lane of the array with its own write enable and registered read.
module wb4_lane_mem import wb4_pkg::*; #(
   parameter  int AW = 6,
   localparam int DEPTH = 1 << AW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic              en_n,
   input  logic [AW-1:0]     waddr,
   input  logic [LANE_W-1:0] wdata,
   input  logic [AW-1:0]     raddr,
   output logic [LANE_W-1:0] rdata
);
   logic [LANE_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we && !en_n) mem[waddr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rdata <= '0;
      else        rdata <= mem[raddr];
   end

   // R9: read data is zero while reset is applied
   p_rd_reset_r9: assert property (@(posedge clk) !rst_n |-> rdata == '0);
endmodule

// File: rtl/wb4_write_port.sv
`timescale 1ns/1ps
module wb4_write_port import wb4_pkg::*; #(
   parameter  int DW    = 36,
   parameter  int AW    = 6,
   localparam int LANES = DW / LANE_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             k_phase,
   input  logic             wr_n,
   input  logic [AW-1:0]    wr_addr,
   input  logic [DW-1:0]    din,
   input  logic [LANES-1:0] bw_n,
   input  logic [AW-1:0]    rd_addr,
   output logic [DW-1:0]    rd_data
);
   // R10: supported configurations only
   if (DW != 2 * LANE_W && DW != 4 * LANE_W) begin : g_bad_dw
      $error("wb4_write_port: DW must be 18 or 36");
   end
   if (AW < BEAT_IDX_W + 1) begin : g_bad_aw
      $error("wb4_write_port: AW must be at least 3");
   end

   logic          we;
   logic [AW-1:0] waddr;

   wb4_sched #(.AW(AW)) u_sched (
      .clk      (clk),
      .rst_n    (rst_n),
      .k_phase  (k_phase),
      .wr_n     (wr_n),
      .cmd_addr (wr_addr),
      .we       (we),
      .waddr    (waddr)
   );

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      wb4_lane_mem #(.AW(AW)) u_lane (
         .clk   (clk),
         .rst_n (rst_n),
         .we    (we),
         .en_n  (bw_n[l]),
         .waddr (waddr),
         .wdata (din[l*LANE_W +: LANE_W]),
         .raddr (rd_addr),
         .rdata (rd_data[l*LANE_W +: LANE_W])
      );
   end
endmodule

// File: tb/tb_wb4_write_port.sv
`timescale 1ns/1ps
module tb_wb4_write_port;
   localparam int DW = 36;
   localparam int AW = 4;
   localparam int LN = DW / 9;
   localparam int UW = AW - 2;
   localparam int DEPTH = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          kph = 1'b1;
   logic          wr_n = 1'b1;
   logic [AW-1:0] wr_addr = '0;
   logic [DW-1:0] din = '0;
   logic [LN-1:0] bw_n = '1;
   logic [AW-1:0] rd_addr = '0;
   logic [DW-1:0] rd_data;

   logic [DW-1:0] refm [DEPTH];
   int checks = 0;
   int errs = 0;

   wb4_write_port #(.DW(DW), .AW(AW)) dut (
      .clk(clk), .rst_n(rst_n), .k_phase(kph), .wr_n(wr_n), .wr_addr(wr_addr),
      .din(din), .bw_n(bw_n), .rd_addr(rd_addr), .rd_data(rd_data)
   );

   always #5 clk = ~clk;
   always @(negedge clk) kph <= !rst_n ? 1'b1 : ~kph;

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errs, checks);
   endtask

   initial begin
      #1000000;
      errs++;
      $display("FAIL watchdog: run did not complete (actual hung, expected done)");
      summary();
      $finish;
   end

   task automatic drive_idle();
      wr_n    = 1'b1;
      wr_addr = AW'($urandom());
      din     = DW'({$urandom(), $urandom()});
      bw_n    = LN'($urandom());
   endtask

   // One fast-clock slot: inputs set just after the falling edge.
   task automatic nxt();
      @(negedge clk); #1;
      drive_idle();
   endtask

   task automatic nxt_k();
      nxt();
      if (!kph) nxt();
   endtask

   task automatic apply(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [LN-1:0] b);
      for (int l = 0; l < LN; l++)
         if (!b[l]) refm[a][l*9 +: 9] = d[l*9 +: 9];
   endtask

   task automatic beat(input logic [AW-1:0] a, input bit full);
      din  = DW'({$urandom(), $urandom()});
      bw_n = full ? '0 : LN'($urandom());
      apply(a, din, bw_n);
   endtask

   task automatic chk(input logic [AW-1:0] a, input string tag);
      nxt();
      rd_addr = a;
      @(negedge clk); #1;
      checks++;
      if (rd_data !== refm[a]) begin
         errs++;
         $display("FAIL %s addr %0d: actual %h expected %h", tag, a, rd_data, refm[a]);
      end
   endtask

   task automatic chk_all(input string tag);
      for (int a = 0; a < DEPTH; a++) chk(AW'(a), tag);
   endtask

   // Commands on every other K edge from base b0; beats gapless (R2 R3 R4 R8).
   task automatic t_stream(input int n, input int b0, input bit full);
      for (int t = 0; t < 4 * n + 2; t++) begin
         if (t == 0) nxt_k(); else nxt();
         if (t % 4 == 0 && t / 4 < n) begin
            wr_n    = 1'b0;
            wr_addr = {UW'(b0 + t / 4), 2'($urandom())};
         end
         if (t >= 2) beat({UW'(b0 + (t - 2) / 4), 2'((t - 2) % 4)}, full);
      end
   endtask

   // R5: third command while the holding slot is full is dropped.
   task automatic t_overflow();
      for (int t = 0; t < 10; t++) begin
         if (t == 0) nxt_k(); else nxt();
         if (t == 0 || t == 2 || t == 4) begin
            wr_n    = 1'b0;
            wr_addr = {UW'(t / 2), 2'($urandom())};
         end
         if (t >= 2 && t < 6) beat({UW'(0), 2'(t - 2)}, 1'b0);
         if (t >= 6)          beat({UW'(1), 2'(t - 6)}, 1'b0);
      end
      chk_all("R5 overflow drop / R4 queue");
   endtask

   // R1 and R6: strobe on a K-bar edge and junk data on idle slots write nothing.
   task automatic t_kbar_idle();
      nxt_k();
      nxt();
      wr_n = 1'b0;
      wr_addr = {UW'(3), 2'b00};
      for (int t = 0; t < 12; t++) nxt();
      chk_all("R1 R6 no write outside bursts");
   endtask

   initial begin
      drive_idle();
      repeat (3) @(negedge clk);
      #1;
      checks++;
      if (rd_data !== '0) begin
         errs++;
         $display("FAIL R9 reset: actual %h expected 0", rd_data);
      end
      rst_n = 1'b1;
      repeat (2) nxt();
      t_stream(DEPTH / 4, 0, 1'b1);
      chk_all("R2 R3 R4 R8 full-lane stream");
      t_stream(1, 2, 1'b0);
      for (int i = 0; i < 4; i++) chk({UW'(2), 2'(i)}, "R7 byte lanes");
      t_stream(3, 1, 1'b0);
      chk_all("R4 R7 masked stream");
      t_overflow();
      t_kbar_idle();
      summary();
      $finish;
   end
endmodule